// File: doc/BRIEF.md
# Nested Zero-Overhead Loop Sequencer

This block owns the program counter of a small streaming processing element and lets a program run nested counted loops without spending any cycle on branch or counter instructions. When the decoder reports a repeat instruction, it supplies a repetition count, the first line of the loop body and the last line of the loop body. The sequencer opens a new loop level, jumps to the first body line, and from then on compares every executed line with the innermost level's last line. On a match it either goes back to the first body line and decrements that level's count, or it closes the level and falls through into the enclosing level.

The outermost level is implicit. It always exists, starts at line 0, and never ends. Deeper levels live in a small stack whose depth is a build-time parameter. A second parameter removes the loop machinery altogether, which leaves a plain incrementing counter with branch support. Taken branches and jumps, reported by the decoder, always win over the loop logic for the cycle in which they occur.

Top module: `nestLoopPc`

## Requirements
- R1: While `rstN` is low, `pc` is 0, `depth` is 0 and `overflow` is 0.
- R2: When `step` is high and neither a branch, a repeat nor an end-line match applies, `pc` advances by 1 modulo 2^PC_W on the next clock.
- R3: When `step` is low, `pc`, `depth` and `overflow` keep their values.
- R4: A repeat instruction (`rptValid` high while `step` is high, no branch) with `depth` below MAX_DEPTH raises `depth` by 1 and loads `pc` with `rptStart` on the next clock.
- R5: When the executed line equals the innermost level's end line and that level's remaining count is nonzero, `pc` returns to that level's start line and the count drops by 1, so a repeat with count N runs its body N+1 times.
- R6: When the executed line equals the innermost level's end line and its remaining count is zero, `depth` drops by 1 and `pc` advances by 1.
- R7: After an inner level closes, the enclosing level carries on with its own start, end and remaining count, and a repeat met again inside an outer body reopens the inner level with a fresh count.
- R8: A repeat instruction met while `depth` equals MAX_DEPTH is ignored (`pc` advances by 1, `depth` unchanged) and sets `overflow`, which then stays high until reset.
- R9: A taken branch (`brTaken` high while `step` is high) loads `brTarget` into `pc` and leaves the loop levels untouched, with no push, no pop and no count decrement, even on an end line or a repeat line.
- R10: An end line of all ones never matches `pc`, so such a level runs until left by a branch; the implicit outermost level (`depth` 0) never closes, and `pc` wraps from all ones to 0.
- R11: With ENABLE set to 0, `rptValid` has no effect: `depth` stays 0, `overflow` stays 0 and `pc` only increments or branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| step | input | 1 | The line at `pc` executes this cycle |
| brTaken | input | 1 | The executed line is a taken branch or jump |
| brTarget | input | PC_W | Destination of the taken branch |
| rptValid | input | 1 | The executed line is a repeat instruction |
| rptCount | input | CNT_W | Extra passes N of the loop body |
| rptStart | input | PC_W | First line of the loop body |
| rptEnd | input | PC_W | Last line of the loop body; all ones means never ending |
| pc | output | PC_W | Line being executed |
| depth | output | $clog2(MAX_DEPTH+1) | Number of open loop levels |
| overflow | output | 1 | Sticky flag, a repeat was dropped for lack of a level |

## Verification
A stale count or a wrong level pointer stays invisible until the next end-line match, where `pc` jumps to the wrong start line, or falls through one pass early or late. That mistake therefore shows up within one body length of the fault, and the nested sweeps compare every `pc` value of every pass against the expected sequence. A level that was pushed or popped in error shows on `depth` on the very next clock. A branch that touched the stack shows later, as a wrong number of passes after the program returns into the loop.

// File: rtl/nestLoopPkg.sv
package nestLoopPkg;

  // Source of the next program counter value
  typedef enum logic [2:0] {
    PC_HOLD  = 3'd0,
    PC_INC   = 3'd1,
    PC_JUMP  = 3'd2,
    PC_LOOP  = 3'd3,
    PC_ENTER = 3'd4
  } pcSelT;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic  push;
    logic  pop;
    logic  dec;
    logic  setOvf;
    pcSelT pcSel;
  } seqStrobeT;

endpackage

// File: rtl/loopCtrl.sv
module loopCtrl
  import nestLoopPkg::*;
#(
  parameter int PC_W      = 10,
  parameter int CNT_W     = 8,
  parameter int MAX_DEPTH = 4,
  parameter int ENABLE    = 1,
  localparam int LVL_W    = $clog2(MAX_DEPTH + 1)
) (
  input  logic             step,
  input  logic             brTaken,
  input  logic             rptValid,
  input  logic [PC_W-1:0]  pc,
  input  logic [PC_W-1:0]  topEnd,
  input  logic [CNT_W-1:0] topCnt,
  input  logic [LVL_W-1:0] level,
  output seqStrobeT        strobe
);

  localparam logic [PC_W-1:0] END_INF = {PC_W{1'b1}};

  logic rptEff;
  logic atMax;
  logic endHit;

  generate
    if (ENABLE != 0) begin : gRptOn
      assign rptEff = rptValid;
    end else begin : gRptOff
      assign rptEff = rptValid & 1'b0;
    end
  endgenerate

  assign atMax  = (level == LVL_W'(MAX_DEPTH));
  assign endHit = (level != '0) && (topEnd != END_INF) && (pc == topEnd);

  always_comb begin
    strobe       = '0;
    strobe.pcSel = PC_HOLD;
    if (step) begin
      if (brTaken) begin
        strobe.pcSel = PC_JUMP;
      end else if (rptEff) begin
        if (atMax) begin
          strobe.setOvf = 1'b1;
          strobe.pcSel  = PC_INC;
        end else begin
          strobe.push  = 1'b1;
          strobe.pcSel = PC_ENTER;
        end
      end else if (endHit) begin
        if (topCnt != '0) begin
          strobe.dec   = 1'b1;
          strobe.pcSel = PC_LOOP;
        end else begin
          strobe.pop   = 1'b1;
          strobe.pcSel = PC_INC;
        end
      end else begin
        strobe.pcSel = PC_INC;
      end
    end
  end

endmodule

// File: rtl/loopStack.sv
module loopStack
  import nestLoopPkg::*;
#(
  parameter int PC_W      = 10,
  parameter int CNT_W     = 8,
  parameter int MAX_DEPTH = 4,
  parameter int ENABLE    = 1,
  localparam int LVL_W    = $clog2(MAX_DEPTH + 1),
  localparam int ENTRIES  = MAX_DEPTH + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobeT        strobe,
  input  logic [PC_W-1:0]  brTarget,
  input  logic [CNT_W-1:0] rptCount,
  input  logic [PC_W-1:0]  rptStart,
  input  logic [PC_W-1:0]  rptEnd,
  output logic [PC_W-1:0]  pc,
  output logic [LVL_W-1:0] level,
  output logic             overflow,
  output logic [PC_W-1:0]  topStart,
  output logic [PC_W-1:0]  topEnd,
  output logic [CNT_W-1:0] topCnt
);

  localparam logic [PC_W-1:0] END_INF = {PC_W{1'b1}};

  logic [PC_W-1:0]  startArr [ENTRIES];
  logic [PC_W-1:0]  endArr   [ENTRIES];
  logic [CNT_W-1:0] cntArr   [ENTRIES];
  logic [PC_W-1:0]  pcNext;

  // Entry 0 is the implicit, never ending outermost level
  assign startArr[0] = '0;
  assign endArr[0]   = END_INF;
  assign cntArr[0]   = '0;

  generate
    for (genvar g = 1; g < ENTRIES; g++) begin : gLvl
      if (ENABLE != 0) begin : gLive
        logic [PC_W-1:0]  sQ;
        logic [PC_W-1:0]  eQ;
        logic [CNT_W-1:0] cQ;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            sQ <= '0;
            eQ <= END_INF;
            cQ <= '0;
          end else if (strobe.push && (level == LVL_W'(g - 1))) begin
            sQ <= rptStart;
            eQ <= rptEnd;
            cQ <= rptCount;
          end else if (strobe.dec && (level == LVL_W'(g))) begin
            cQ <= cQ - CNT_W'(1);
          end
        end
        assign startArr[g] = sQ;
        assign endArr[g]   = eQ;
        assign cntArr[g]   = cQ;
      end else begin : gTied
        assign startArr[g] = '0;
        assign endArr[g]   = END_INF;
        assign cntArr[g]   = '0;
      end
    end
  endgenerate

  assign topStart = startArr[level];
  assign topEnd   = endArr[level];
  assign topCnt   = cntArr[level];

  always_comb begin
    unique case (strobe.pcSel)
      PC_INC:   pcNext = pc + PC_W'(1);
      PC_JUMP:  pcNext = brTarget;
      PC_LOOP:  pcNext = topStart;
      PC_ENTER: pcNext = rptStart;
      default:  pcNext = pc;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc       <= '0;
      level    <= '0;
      overflow <= 1'b0;
    end else begin
      pc <= pcNext;
      if (strobe.push) begin
        level <= level + LVL_W'(1);
      end else if (strobe.pop) begin
        level <= level - LVL_W'(1);
      end
      if (strobe.setOvf) begin
        overflow <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/nestLoopPc.sv
module nestLoopPc
  import nestLoopPkg::*;
#(
  parameter int PC_W      = 10,
  parameter int CNT_W     = 8,
  parameter int MAX_DEPTH = 4,
  parameter int ENABLE    = 1,
  localparam int LVL_W    = $clog2(MAX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             step,
  input  logic             brTaken,
  input  logic [PC_W-1:0]  brTarget,
  input  logic             rptValid,
  input  logic [CNT_W-1:0] rptCount,
  input  logic [PC_W-1:0]  rptStart,
  input  logic [PC_W-1:0]  rptEnd,
  output logic [PC_W-1:0]  pc,
  output logic [LVL_W-1:0] depth,
  output logic             overflow
);

  seqStrobeT        strobe;
  logic [PC_W-1:0]  topStart;
  logic [PC_W-1:0]  topEnd;
  logic [CNT_W-1:0] topCnt;
  logic [LVL_W-1:0] level;

  loopCtrl #(
    .PC_W(PC_W), .CNT_W(CNT_W), .MAX_DEPTH(MAX_DEPTH), .ENABLE(ENABLE)
  ) uCtrl (
    .step(step), .brTaken(brTaken), .rptValid(rptValid), .pc(pc),
    .topEnd(topEnd), .topCnt(topCnt), .level(level), .strobe(strobe)
  );

  loopStack #(
    .PC_W(PC_W), .CNT_W(CNT_W), .MAX_DEPTH(MAX_DEPTH), .ENABLE(ENABLE)
  ) uStack (
    .clk(clk), .rstN(rstN), .strobe(strobe), .brTarget(brTarget),
    .rptCount(rptCount), .rptStart(rptStart), .rptEnd(rptEnd),
    .pc(pc), .level(level), .overflow(overflow),
    .topStart(topStart), .topEnd(topEnd), .topCnt(topCnt)
  );

  assign depth = level;

endmodule

// File: rtl/nestLoopPcChk.sv
module nestLoopPcChk #(
  parameter int PC_W      = 10,
  parameter int MAX_DEPTH = 4,
  parameter int ENABLE    = 1,
  localparam int LVL_W    = $clog2(MAX_DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             step,
  input logic             brTaken,
  input logic [PC_W-1:0]  brTarget,
  input logic             rptValid,
  input logic [PC_W-1:0]  rptStart,
  input logic [PC_W-1:0]  pc,
  input logic [LVL_W-1:0] depth,
  input logic             overflow
);

  // R3
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !step |=> ($stable(pc) && $stable(depth) && $stable(overflow)));

  // R8
  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R9
  a_r9_branch_wins: assert property (@(posedge clk) disable iff (!rstN)
    (step && brTaken) |=> (pc == $past(brTarget)) && (depth == $past(depth)));

  // R4, R6
  a_r4_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
    depth <= LVL_W'(MAX_DEPTH));

  generate
    if (ENABLE != 0) begin : gOn
      // R4
      a_r4_push_enters: assert property (@(posedge clk) disable iff (!rstN)
        (step && !brTaken && rptValid && (depth != LVL_W'(MAX_DEPTH)))
        |=> (depth == LVL_W'($past(depth) + 1'b1)) && (pc == $past(rptStart)));
      // R8
      a_r8_full_ignored: assert property (@(posedge clk) disable iff (!rstN)
        (step && !brTaken && rptValid && (depth == LVL_W'(MAX_DEPTH)))
        |=> overflow && (depth == $past(depth)) && (pc == PC_W'($past(pc) + 1'b1)));
    end else begin : gOff
      // R11
      a_r11_no_levels: assert property (@(posedge clk) disable iff (!rstN)
        (depth == '0) && !overflow);
    end
  endgenerate

endmodule

bind nestLoopPc nestLoopPcChk #(
  .PC_W(PC_W), .MAX_DEPTH(MAX_DEPTH), .ENABLE(ENABLE)
) uChk (
  .clk(clk), .rstN(rstN), .step(step), .brTaken(brTaken), .brTarget(brTarget),
  .rptValid(rptValid), .rptStart(rptStart), .pc(pc), .depth(depth),
  .overflow(overflow)
);

// File: tb/test_nestLoopPc.sv
`timescale 1ns/1ps
module test_nestLoopPc;

  localparam int PW = 6;
  localparam int CW = 3;
  localparam int MD = 2;
  localparam int LW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rstN, step, brTaken, rptValid;
  logic [PW-1:0] brTarget, rptStart, rptEnd;
  logic [CW-1:0] rptCount;
  logic [PW-1:0] pc, offPc;
  logic [LW-1:0] depth, offDepth;
  logic          overflow, offOvf;

  nestLoopPc #(.PC_W(PW), .CNT_W(CW), .MAX_DEPTH(MD), .ENABLE(1)) i_nestLoopPc (
    .clk(clk), .rstN(rstN), .step(step), .brTaken(brTaken), .brTarget(brTarget),
    .rptValid(rptValid), .rptCount(rptCount), .rptStart(rptStart), .rptEnd(rptEnd),
    .pc(pc), .depth(depth), .overflow(overflow));

  nestLoopPc #(.PC_W(PW), .CNT_W(CW), .MAX_DEPTH(MD), .ENABLE(0)) i_nestLoopPcOff (
    .clk(clk), .rstN(rstN), .step(step), .brTaken(brTaken), .brTarget(brTarget),
    .rptValid(rptValid), .rptCount(rptCount), .rptStart(rptStart), .rptEnd(rptEnd),
    .pc(offPc), .depth(offDepth), .overflow(offOvf));

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit offTrack = 1'b0;
  int offExp = 0;
  int nProg = 0;
  int progLine[4], progN[4], progS[4], progE[4];

  task automatic checkVal(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic addRpt(input int line, input int n, input int s, input int e);
    progLine[nProg] = line; progN[nProg] = n; progS[nProg] = s; progE[nProg] = e;
    nProg++;
  endtask

  // Decoder model: flags a repeat when pc sits on a programmed repeat line
  task automatic driveRpt();
    rptValid = 1'b0; rptCount = '0; rptStart = '0; rptEnd = '0;
    for (int i = 0; i < nProg; i++) begin
      if (int'(pc) == progLine[i]) begin
        rptValid = 1'b1;
        rptCount = CW'(progN[i]);
        rptStart = PW'(progS[i]);
        rptEnd   = PW'(progE[i]);
      end
    end
  endtask

  task automatic stepPc(input int exp, input int expDepth, input string tag);
    checkVal(int'(pc), exp, tag);
    if (expDepth >= 0) checkVal(int'(depth), expDepth, {tag, " depth"});
    if (offTrack) begin
      checkVal(int'(offPc), offExp % 64, "R11 disabled pc");
      checkVal(int'(offDepth) + int'(offOvf), 0, "R11 disabled depth/overflow");
      offExp++;
    end
    driveRpt();
    @(negedge clk);
  endtask

  task automatic resetDut();
    rstN = 1'b0; step = 1'b1; brTaken = 1'b0; brTarget = '0; nProg = 0;
    driveRpt();
    repeat (2) @(negedge clk);
    checkVal(int'(pc), 0, "R1 reset pc");
    checkVal(int'(depth), 0, "R1 reset depth");
    checkVal(int'(overflow), 0, "R1 reset overflow");
    rstN = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R4 R5 R6 R2: single loop, body length 1..3, count 0..7
    for (int e = 3; e <= 5; e++) begin
      for (int n = 0; n < 8; n++) begin
        resetDut();
        addRpt(2, n, 3, e);
        offTrack = (n == 2 && e == 5);
        offExp = 0;
        stepPc(0, 0, "R2 line 0");
        stepPc(1, 0, "R2 line 1");
        stepPc(2, 0, "R4 repeat line");
        for (int it = 0; it <= n; it++)
          for (int l = 3; l <= e; l++)
            stepPc(l, 1, "R5 body pass");
        stepPc(e + 1, 0, "R6 loop exit");
        stepPc(e + 2, 0, "R2 after loop");
        offTrack = 1'b0;
      end
    end

    // R7: nested loops, outer 2..7, inner 4..5 opened at line 3
    for (int n1 = 0; n1 < 4; n1++) begin
      for (int n2 = 0; n2 < 4; n2++) begin
        resetDut();
        addRpt(1, n1, 2, 7);
        addRpt(3, n2, 4, 5);
        stepPc(0, 0, "R7 line 0");
        stepPc(1, 0, "R7 outer repeat");
        for (int i = 0; i <= n1; i++) begin
          stepPc(2, 1, "R7 outer body");
          stepPc(3, 1, "R7 inner repeat");
          for (int j = 0; j <= n2; j++) begin
            stepPc(4, 2, "R7 inner body");
            stepPc(5, 2, "R7 inner end");
          end
          stepPc(6, 1, "R7 outer resumes");
          stepPc(7, 1, "R7 outer end");
        end
        stepPc(8, 0, "R7 all closed");
        stepPc(9, 0, "R7 after");
      end
    end

    // R8: third repeat with only two levels
    resetDut();
    addRpt(1, 0, 2, 20);
    addRpt(2, 0, 3, 19);
    addRpt(3, 0, 4, 18);
    stepPc(0, 0, "R8 line 0");
    stepPc(1, 0, "R8 first repeat");
    stepPc(2, 1, "R8 second repeat");
    checkVal(int'(overflow), 0, "R8 clear before full");
    stepPc(3, 2, "R8 third repeat");
    checkVal(int'(overflow), 1, "R8 overflow set");
    for (int p = 4; p <= 19; p++) stepPc(p, 2, "R8 repeat ignored");
    stepPc(20, 1, "R6 pop to outer");
    stepPc(21, 0, "R6 pop to top");
    checkVal(int'(overflow), 1, "R8 overflow sticky");

    // R9 and R3: branch out of and back into a loop, then a hold
    resetDut();
    addRpt(2, 3, 3, 5);
    stepPc(0, 0, "R9 line 0");
    stepPc(1, 0, "R9 line 1");
    stepPc(2, 0, "R9 repeat");
    stepPc(3, 1, "R9 body");
    stepPc(4, 1, "R9 body");
    checkVal(int'(pc), 5, "R9 at end line");
    brTaken = 1'b1; brTarget = 6'd10; driveRpt();
    @(negedge clk);
    brTaken = 1'b0;
    checkVal(int'(pc), 10, "R9 branch target");
    checkVal(int'(depth), 1, "R9 level kept");
    stepPc(10, 1, "R9 outside body");
    stepPc(11, 1, "R9 outside body");
    checkVal(int'(pc), 12, "R9 before return");
    brTaken = 1'b1; brTarget = 6'd3; driveRpt();
    @(negedge clk);
    brTaken = 1'b0;
    step = 1'b0;
    repeat (3) @(negedge clk);
    checkVal(int'(pc), 3, "R3 pc held");
    checkVal(int'(depth), 1, "R3 depth held");
    checkVal(int'(overflow), 0, "R3 overflow held");
    step = 1'b1;
    for (int it = 0; it <= 3; it++)
      for (int l = 3; l <= 5; l++)
        stepPc(l, 1, "R9 count untouched by branch");
    stepPc(6, 0, "R9 exit after full count");

    // R10: never ending loop, pc wraps without a pop
    resetDut();
    addRpt(1, 2, 2, 63);
    stepPc(0, 0, "R10 line 0");
    stepPc(1, 0, "R10 repeat");
    for (int p = 2; p <= 63; p++) stepPc(p, 1, "R10 no end match");
    stepPc(0, 1, "R10 wrap keeps level");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule